// File: doc/BRIEF.md
# Transmit Buffer Priority Arbiter

This block keeps an 8-bit local priority value for each transmit message buffer of a bus controller. When the controller is ready to send another frame, it asks the block to arbitrate. The block then reports which buffer goes next. Only buffers that hold a message waiting for transmission take part. A buffer holds such a message when its empty flag is low. The numerically smallest priority value wins. If several waiting buffers share that smallest value, the buffer with the lower index wins.

Software reaches the priority values through a byte-wide port. A one-hot select input points at one buffer. Software may read or write that buffer's priority only while the buffer is flagged empty, so the value cannot change under a message that is waiting to go out. No data streams through the block. Every pin is a plain control or status level sampled on the clock, and there is no valid/ready handshake and no back-pressure.

Top module: `txprio_arbiter`

## Requirements
- R1: After reset, every priority register is 0x00, `win_valid` is 0 and `win_idx` is 0.
- R2: Among pending buffers, arbitration picks the buffer with the numerically smallest priority value.
- R3: If two or more pending buffers share the smallest value, the one with the lowest index wins.
- R4: Buffer i is pending when `buf_empty[i]` (bit i belongs to buffer i) is 0. A buffer whose empty bit is 1 never wins, whatever its priority.
- R5: `cpu_rdata` shows the selected buffer's priority only while `buf_sel` has exactly one bit set and that buffer's empty bit is 1. Otherwise `cpu_rdata` reads 0x00.
- R6: A write (`cpu_wr_en` high at a rising edge) loads `cpu_wdata` into the selected buffer's priority only under the same condition as R5. Otherwise the write is dropped and every priority register keeps its value.
- R7: If arbitration is requested while no buffer is pending, `win_valid` becomes 0 and `win_idx` keeps its previous value.
- R8: If `buf_sel` has more than one bit set (or none), it counts as no selection: reads give 0x00 and writes are dropped.
- R9: `win_idx` and `win_valid` update only at the rising edge where `arb_start` is high, one cycle after the request is presented. At all other edges they hold, even when the flags or priorities change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_empty | input | NUM_BUFS | Per-buffer empty flag, bit i for buffer i |
| buf_sel | input | NUM_BUFS | One-hot buffer select for CPU access |
| cpu_wr_en | input | 1 | Write strobe for the selected priority register |
| cpu_wdata | input | PRIO_W | Write data |
| cpu_rdata | output | PRIO_W | Priority of the selected buffer, or 0 when access is not allowed |
| arb_start | input | 1 | Request to arbitrate among pending buffers |
| win_idx | output | IDX_W | Index of the winning buffer |
| win_valid | output | 1 | A pending buffer was found at the last arbitration |

## Verification
The bench builds the block with its default three buffers and 8-bit priorities. At this size every empty-flag pattern can be set up. The extreme values 0x00 and 0xFF can be placed in the same arbitration, and three-way ties are possible. With three buffers, a select code with two bits set is also legal to drive, so the multi-select block on accesses (R8) can be exercised next to single-select access to a buffer that is not empty.

// File: rtl/txprio_pkg.sv
package txprio_pkg;
  localparam int DEF_NUM_BUFS = 3;
  localparam int DEF_PRIO_W   = 8;

  // Width of an index into NUM_BUFS buffers (at least one bit)
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/txprio_access.sv
// Decodes the CPU select vector into an index and an access permit.
module txprio_access
  import txprio_pkg::*;
#(
  parameter int NUM_BUFS = DEF_NUM_BUFS,
  localparam int IDX_W   = idx_width(NUM_BUFS)
) (
  input  logic [NUM_BUFS-1:0] buf_sel,
  input  logic [NUM_BUFS-1:0] buf_empty,
  output logic [IDX_W-1:0]    sel_idx,
  output logic                sel_ok
);
  logic single;
  logic [IDX_W-1:0] enc [NUM_BUFS+1];

  assign single = $onehot(buf_sel);

  // OR-encode the select vector; valid only when it is one-hot
  assign enc[0] = '0;
  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_enc
    assign enc[g+1] = enc[g] | (buf_sel[g] ? IDX_W'(g) : '0);
  end

  assign sel_idx = enc[NUM_BUFS];
  assign sel_ok  = single && ((buf_sel & buf_empty) != '0);
endmodule

// File: rtl/txprio_regs.sv
// Priority register file with gated write and gated read.
module txprio_regs
  import txprio_pkg::*;
#(
  parameter int NUM_BUFS = DEF_NUM_BUFS,
  parameter int PRIO_W   = DEF_PRIO_W,
  localparam int IDX_W   = idx_width(NUM_BUFS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           acc_ok,
  input  logic [IDX_W-1:0]               acc_idx,
  input  logic [PRIO_W-1:0]              wdata,
  output logic [PRIO_W-1:0]              rdata,
  output logic [NUM_BUFS-1:0][PRIO_W-1:0] prio
);
  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && acc_ok && (acc_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio[g] <= '0;
      else if (hit) prio[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BUFS; i++) begin
      if (acc_ok && (acc_idx == IDX_W'(i))) rdata = prio[i];
    end
  end
endmodule

// File: rtl/txprio_pick.sv
// Combinational search for the pending buffer with the smallest priority.
module txprio_pick
  import txprio_pkg::*;
#(
  parameter int NUM_BUFS = DEF_NUM_BUFS,
  parameter int PRIO_W   = DEF_PRIO_W,
  localparam int IDX_W   = idx_width(NUM_BUFS)
) (
  input  logic [NUM_BUFS-1:0]             buf_empty,
  input  logic [NUM_BUFS-1:0][PRIO_W-1:0] prio,
  output logic [IDX_W-1:0]                best_idx,
  output logic                            found
);
  logic [PRIO_W-1:0] best_val;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_val = '0;
    // Ascending scan with strict less-than: ties stay with the lower index
    for (int i = 0; i < NUM_BUFS; i++) begin
      if (!buf_empty[i] && (!found || (prio[i] < best_val))) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_val = prio[i];
      end
    end
  end
endmodule

// File: rtl/txprio_arbiter.sv
module txprio_arbiter
  import txprio_pkg::*;
#(
  parameter int NUM_BUFS = DEF_NUM_BUFS,
  parameter int PRIO_W   = DEF_PRIO_W,
  localparam int IDX_W   = idx_width(NUM_BUFS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BUFS-1:0] buf_empty,
  input  logic [NUM_BUFS-1:0] buf_sel,
  input  logic                cpu_wr_en,
  input  logic [PRIO_W-1:0]   cpu_wdata,
  output logic [PRIO_W-1:0]   cpu_rdata,
  input  logic                arb_start,
  output logic [IDX_W-1:0]    win_idx,
  output logic                win_valid
);
  logic [IDX_W-1:0]               acc_idx;
  logic                           acc_ok;
  logic [NUM_BUFS-1:0][PRIO_W-1:0] prio;
  logic [IDX_W-1:0]               best_idx;
  logic                           found;

  txprio_access #(.NUM_BUFS(NUM_BUFS)) u_acc (
    .buf_sel   (buf_sel),
    .buf_empty (buf_empty),
    .sel_idx   (acc_idx),
    .sel_ok    (acc_ok)
  );

  txprio_regs #(.NUM_BUFS(NUM_BUFS), .PRIO_W(PRIO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr_en),
    .acc_ok  (acc_ok),
    .acc_idx (acc_idx),
    .wdata   (cpu_wdata),
    .rdata   (cpu_rdata),
    .prio    (prio)
  );

  txprio_pick #(.NUM_BUFS(NUM_BUFS), .PRIO_W(PRIO_W)) u_pick (
    .buf_empty (buf_empty),
    .prio      (prio),
    .best_idx  (best_idx),
    .found     (found)
  );

  // Result captured only on a request; index held when nothing is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_idx   <= '0;
      win_valid <= 1'b0;
    end else if (arb_start) begin
      win_valid <= found;
      if (found) win_idx <= best_idx;
    end
  end
endmodule

// File: rtl/txprio_arbiter_chk.sv
module txprio_arbiter_chk #(
  parameter int NUM_BUFS = 3,
  parameter int PRIO_W   = 8,
  parameter int IDX_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_BUFS-1:0] buf_empty,
  input logic [NUM_BUFS-1:0] buf_sel,
  input logic                arb_start,
  input logic [PRIO_W-1:0]   cpu_rdata,
  input logic [IDX_W-1:0]    win_idx,
  input logic                win_valid
);
  // R9
  hold_without_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arb_start) |-> ($stable(win_idx) && $stable(win_valid)));

  // R7
  no_pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arb_start) && ($past(buf_empty) == '1)) |-> (!win_valid && $stable(win_idx)));

  // R4
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arb_start) && win_valid) |-> (($past(buf_empty) >> win_idx) & 1) == 0);

  // R5
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($onehot(buf_sel) && ((buf_sel & buf_empty) != '0)) |-> (cpu_rdata == '0));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (int'(win_idx) < NUM_BUFS));
endmodule

bind txprio_arbiter txprio_arbiter_chk #(
  .NUM_BUFS (NUM_BUFS),
  .PRIO_W   (PRIO_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_empty (buf_empty),
  .buf_sel   (buf_sel),
  .arb_start (arb_start),
  .cpu_rdata (cpu_rdata),
  .win_idx   (win_idx),
  .win_valid (win_valid)
);

// File: tb/sim_txprio_arbiter.sv
`timescale 1ns/1ps
module sim_txprio_arbiter;
  localparam int NB = 3;
  localparam int PW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] buf_empty = '1;
  logic [NB-1:0] buf_sel = '0;
  logic          cpu_wr_en = 1'b0;
  logic [PW-1:0] cpu_wdata = '0;
  logic [PW-1:0] cpu_rdata;
  logic          arb_start = 1'b0;
  logic [IW-1:0] win_idx;
  logic          win_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txprio_arbiter #(.NUM_BUFS(NB), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .buf_empty(buf_empty), .buf_sel(buf_sel),
    .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .arb_start(arb_start), .win_idx(win_idx), .win_valid(win_valid)
  );

  // {empty[2:0], p0, p1, p2, exp_valid, exp_idx[1:0]}
  localparam int NV = 9;
  localparam logic [29:0] VEC [NV] = '{
    {3'b000, 8'd10,  8'd20,  8'd30,  1'b1, 2'd0},  // R2
    {3'b000, 8'd30,  8'd20,  8'd10,  1'b1, 2'd2},  // R2
    {3'b000, 8'd5,   8'd5,   8'd9,   1'b1, 2'd0},  // R3
    {3'b000, 8'd9,   8'd5,   8'd5,   1'b1, 2'd1},  // R3
    {3'b001, 8'd1,   8'd7,   8'd7,   1'b1, 2'd1},  // R4
    {3'b100, 8'd50,  8'd40,  8'd0,   1'b1, 2'd1},  // R4
    {3'b011, 8'd0,   8'd0,   8'd255, 1'b1, 2'd2},  // R4
    {3'b000, 8'd255, 8'd255, 8'd255, 1'b1, 2'd0},  // R3
    {3'b110, 8'd200, 8'd0,   8'd0,   1'b1, 2'd0}   // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int b, input logic [PW-1:0] v);
    @(negedge clk);
    buf_sel = NB'(1) << b;
    cpu_wdata = v;
    cpu_wr_en = 1'b1;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd(input int b, output logic [PW-1:0] v);
    buf_sel = NB'(1) << b;
    #0.5;
    v = cpu_rdata;
  endtask

  task automatic start();
    @(negedge clk);
    arb_start = 1'b1;
    @(negedge clk);
    arb_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [PW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 win_valid", int'(win_valid), 0);
    chk("R1 win_idx", int'(win_idx), 0);
    for (int b = 0; b < NB; b++) begin
      rd(b, r);
      chk("R1 prio reset", int'(r), 0);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      buf_empty = '1;
      wr(0, VEC[v][26:19]);
      wr(1, VEC[v][18:11]);
      wr(2, VEC[v][10:3]);
      rd(1, r);
      chk("R6 write readback", int'(r), int'(VEC[v][18:11]));
      buf_empty = VEC[v][29:27];
      buf_sel = '0;
      start();
      chk("R2/R3/R4 valid", int'(win_valid), int'(VEC[v][2]));
      chk("R2/R3/R4 idx", int'(win_idx), int'(VEC[v][1:0]));
    end

    // R9: hold without request, then update on request
    buf_empty = '1;
    wr(0, 8'd9); wr(1, 8'd9); wr(2, 8'd1);
    buf_empty = 3'b000;
    start();
    chk("R9 setup idx", int'(win_idx), 2);
    @(negedge clk);
    buf_empty = 3'b100;
    @(negedge clk); @(negedge clk);
    chk("R9 held idx", int'(win_idx), 2);
    chk("R9 held valid", int'(win_valid), 1);
    start();
    chk("R9 updated idx", int'(win_idx), 0);

    // R7: nothing pending
    buf_empty = 3'b000;
    start();
    chk("R7 setup idx", int'(win_idx), 2);
    buf_empty = '1;
    start();
    chk("R7 valid low", int'(win_valid), 0);
    chk("R7 idx held", int'(win_idx), 2);

    // R5 / R6: access to a buffer that is not empty
    buf_empty = '1;
    wr(1, 8'h3C);
    buf_empty = 3'b101;
    rd(1, r);
    chk("R5 read blocked", int'(r), 0);
    rd(0, r);
    chk("R5 read allowed", int'(r), 9);
    wr(1, 8'hAA);
    buf_empty = '1;
    rd(1, r);
    chk("R6 write dropped", int'(r), 'h3C);

    // R8: multi-select
    buf_sel = 3'b011;
    #0.5;
    chk("R8 read multi-select", int'(cpu_rdata), 0);
    @(negedge clk);
    buf_sel = 3'b011;
    cpu_wdata = 8'h77;
    cpu_wr_en = 1'b1;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    rd(0, r);
    chk("R8 buf0 unchanged", int'(r), 9);
    rd(1, r);
    chk("R8 buf1 unchanged", int'(r), 'h3C);
    buf_sel = '0;
    #0.5;
    chk("R8 read no-select", int'(cpu_rdata), 0);

    finish_run();
  end
endmodule